// File: doc/BRIEF.md
# Queued Byte-Command SPI Master

This block is an SPI master that works through a short list of byte transfers without further help from the processor. Software first loads a transmit byte and a command word into each slot it needs. It then sets a first-slot pointer and an inclusive last-slot pointer, and writes the enable bit. The engine visits every slot from the first pointer to the last. For each slot it shifts out the transmit byte, most significant bit first, in SPI mode 0, and it stores the byte it receives in a receive file at the same slot index.

Each command word decides three things for its slot: whether chip select stays asserted once the slot ends, which peripheral selects stay quiet, and whether an extra lead delay comes before the first clock edge. A control bit can hold chip select asserted after the last slot, so that the next run carries on the same transaction. A lock register freezes the queue contents while such a transaction is open. The enable bit clears itself when the run completes, and the `done` pin pulses for one cycle at that moment.

Top module: `qspi_queue_master`

## Requirements
- R1: After reset, `sclk` is 0, every `cs_n` bit is 1 (inactive), `done` is 0 and the control word (address 4*SLOTS+2) reads 0.
- R2: A run visits slots from the first pointer (address 4*SLOTS) to the last pointer (address 4*SLOTS+1), both inclusive. For each slot it sends the transmit byte stored at even address 2*slot, MSB first, in SPI mode 0 (`sclk` idles low, MOSI is stable on each rising edge). It produces exactly 8 rising `sclk` edges per slot.
- R3: Each slot stores the byte sampled on MISO at the rising edges, MSB first, into the receive file. The byte reads back at address 3*SLOTS+slot.
- R4: A command word sits at address 2*SLOTS+slot, and its bit 0 always reads back as 0. If its hold bit (bit 7) is 0, chip select is released once the slot ends and stays released for half an `sclk` period before the next slot. If the hold bit is 1, chip select stays asserted into the next slot.
- R5: If the keep bit (control bit 1) is set at start, chip select stays asserted after the last slot, whatever that slot's hold bit says.
- R6: Command bit k+1 set to 1 keeps `cs_n[k]` high for that slot. Peripherals with the bit clear are asserted.
- R7: Writing 1 to control bit 0 while idle starts a run, and this bit reads 1 while the run is in progress. It clears by itself after the final slot. `done` is high for exactly one cycle: the first cycle in which the enable bit reads 0 again.
- R8: While a run is in progress, writes to the transmit file, the command file and both pointers are ignored.
- R9: While the lock register (address 4*SLOTS+3, bit 0) holds 1, writes to the transmit file, the command file and both pointers are ignored. Writing 0 to the lock register lifts the lock.
- R10: If the last pointer is below the first pointer, no slot runs and no `sclk` edge occurs. `done` pulses within two cycles of the start write, and chip select keeps its previous level.
- R11: Command bit 6 lengthens the time from chip-select assertion to the first rising `sclk` edge by exactly LEAD_DLY system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational on address) |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to peripherals |
| miso | input | 1 | Serial data from peripherals |
| cs_n | output | NCS | Active-low peripheral selects |
| done | output | 1 | One-cycle pulse when a run completes |

## Verification
A wrong slot pointer shows at once as a misplaced byte on MOSI and as receive data stored at the wrong index, and it is seen at the first readback after `done`. A wrong chip-select or hold state changes how many times `cs_n[0]` rises during a run and the level it is left at, and both are checked right after each run. Gating faults in the write path appear as changed pointer or file contents on the readback that follows the meddling writes. A wrong lead counter moves the first `sclk` edge by a measurable number of cycles within the same slot.

// File: rtl/qsm_pkg.sv
package qsm_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_ISSUE,
      SQ_WAIT,
      SQ_GAP,
      SQ_FINISH
   } seq_state_t;

   typedef enum logic [1:0] {
      SH_IDLE,
      SH_LEAD,
      SH_HIGH,
      SH_LOW
   } shf_state_t;

   // command word fields
   localparam int unsigned CMD_HOLD_BIT = 7;
   localparam int unsigned CMD_DLY_BIT  = 6;
   // control word fields
   localparam int unsigned CTRL_EN_BIT   = 0;
   localparam int unsigned CTRL_KEEP_BIT = 1;

endpackage

// File: rtl/qsm_regfile.sv
module qsm_regfile
   import qsm_pkg::*;
#(
   parameter int unsigned SLOTS  = 8,
   parameter int unsigned IDX_W  = 3,
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned NCS    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              busy,
   input  logic [IDX_W-1:0]  slot_idx,
   output logic [7:0]        tx_byte,
   output logic              cur_hold,
   output logic              cur_dly,
   output logic [NCS-1:0]    cur_dis,
   input  logic              rx_we,
   input  logic [7:0]        rx_data,
   output logic [IDX_W-1:0]  start_ptr,
   output logic [IDX_W-1:0]  end_ptr,
   output logic              cont_after,
   output logic              start_req
);

   localparam int unsigned CMD_BASE = 2 * SLOTS;
   localparam int unsigned RX_BASE  = 3 * SLOTS;
   localparam int unsigned START_A  = 4 * SLOTS;
   localparam int unsigned END_A    = START_A + 1;
   localparam int unsigned CTRL_A   = START_A + 2;
   localparam int unsigned LOCK_A   = START_A + 3;

   logic [7:0]        tx_mem  [SLOTS];
   logic [DATA_W-1:0] cmd_mem [SLOTS];
   logic [7:0]        rx_mem  [SLOTS];
   logic              lock_q;

   int unsigned      a;
   logic             files_open;
   logic             hit_tx, hit_cmd, hit_rx;
   logic [IDX_W-1:0] tx_slot, cmd_slot, rx_slot;

   always_comb begin
      a          = int'(addr);
      files_open = !busy && !lock_q;
      hit_tx     = (a < CMD_BASE) && !addr[0];
      hit_cmd    = (a >= CMD_BASE) && (a < RX_BASE);
      hit_rx     = (a >= RX_BASE) && (a < START_A);
      tx_slot    = addr[IDX_W:1];
      cmd_slot   = IDX_W'(a - CMD_BASE);
      rx_slot    = IDX_W'(a - RX_BASE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SLOTS; s++) begin
            tx_mem[s]  <= '0;
            cmd_mem[s] <= '0;
            rx_mem[s]  <= '0;
         end
      end else begin
         if (we && files_open && hit_tx)
            tx_mem[tx_slot] <= wdata[7:0];
         if (we && files_open && hit_cmd)
            cmd_mem[cmd_slot] <= wdata & ~DATA_W'(1);
         if (rx_we)
            rx_mem[slot_idx] <= rx_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_ptr  <= '0;
         end_ptr    <= '0;
         cont_after <= 1'b0;
         lock_q     <= 1'b0;
      end else begin
         if (we && files_open && a == START_A) start_ptr <= wdata[IDX_W-1:0];
         if (we && files_open && a == END_A)   end_ptr   <= wdata[IDX_W-1:0];
         if (we && !busy && a == CTRL_A)       cont_after <= wdata[CTRL_KEEP_BIT];
         if (we && a == LOCK_A)                lock_q     <= wdata[0];
      end
   end

   assign start_req = we && !busy && (a == CTRL_A) && wdata[CTRL_EN_BIT];

   always_comb begin
      tx_byte  = tx_mem[slot_idx];
      cur_hold = cmd_mem[slot_idx][CMD_HOLD_BIT];
      cur_dly  = cmd_mem[slot_idx][CMD_DLY_BIT];
      cur_dis  = cmd_mem[slot_idx][NCS:1];
   end

   always_comb begin
      rdata = '0;
      if (hit_tx)            rdata = DATA_W'(tx_mem[tx_slot]);
      else if (hit_cmd)      rdata = cmd_mem[cmd_slot];
      else if (hit_rx)       rdata = DATA_W'(rx_mem[rx_slot]);
      else if (a == START_A) rdata = DATA_W'(start_ptr);
      else if (a == END_A)   rdata = DATA_W'(end_ptr);
      else if (a == CTRL_A) begin
         rdata[CTRL_EN_BIT]   = busy;
         rdata[CTRL_KEEP_BIT] = cont_after;
      end
      else if (a == LOCK_A)  rdata[0] = lock_q;
   end

   // R8: queue setup is frozen for the whole run
   p_frozen_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(start_ptr) && $stable(end_ptr) && $stable(tx_mem[0])));

   // R9: the lock freezes the pointers as well
   p_frozen_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && $past(lock_q)) |-> ($stable(start_ptr) && $stable(end_ptr) && $stable(cmd_mem[0])));

endmodule

// File: rtl/qsm_shifter.sv
module qsm_shifter
   import qsm_pkg::*;
#(
   parameter int unsigned HALF = 2,
   parameter int unsigned DLY  = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   input  logic       dly,
   input  logic [7:0] tx_byte,
   input  logic       miso,
   output logic       sclk,
   output logic       mosi,
   output logic [7:0] rx_byte,
   output logic       done
);

   localparam int unsigned CNT_W = $clog2(HALF + DLY + 1);

   shf_state_t       st_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lead_load;
   logic [7:0]       sh_q;
   logic [2:0]       bit_q;

   generate
      if (DLY == 0) begin : g_lead_plain
         assign lead_load = CNT_W'(HALF - 1);
         logic unused_dly;
         assign unused_dly = dly;
      end else begin : g_lead_ext
         assign lead_load = dly ? CNT_W'(HALF - 1 + DLY) : CNT_W'(HALF - 1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= SH_IDLE;
         cnt_q   <= '0;
         sh_q    <= '0;
         bit_q   <= '0;
         rx_byte <= '0;
         sclk    <= 1'b0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st_q)
            SH_IDLE: if (go) begin
               sh_q  <= tx_byte;
               bit_q <= '0;
               cnt_q <= lead_load;
               st_q  <= SH_LEAD;
            end
            SH_LEAD: if (cnt_q == '0) begin
               sclk    <= 1'b1;
               rx_byte <= {rx_byte[6:0], miso};
               cnt_q   <= CNT_W'(HALF - 1);
               st_q    <= SH_HIGH;
            end else cnt_q <= cnt_q - 1'b1;
            SH_HIGH: if (cnt_q == '0) begin
               sclk  <= 1'b0;
               cnt_q <= CNT_W'(HALF - 1);
               st_q  <= SH_LOW;
               if (bit_q != 3'd7) sh_q <= {sh_q[6:0], 1'b0};
            end else cnt_q <= cnt_q - 1'b1;
            SH_LOW: if (cnt_q == '0) begin
               if (bit_q == 3'd7) begin
                  done <= 1'b1;
                  st_q <= SH_IDLE;
               end else begin
                  bit_q   <= bit_q + 1'b1;
                  sclk    <= 1'b1;
                  rx_byte <= {rx_byte[6:0], miso};
                  cnt_q   <= CNT_W'(HALF - 1);
                  st_q    <= SH_HIGH;
               end
            end else cnt_q <= cnt_q - 1'b1;
            default: st_q <= SH_IDLE;
         endcase
      end
   end

   assign mosi = sh_q[7];

   // R2: a slot always ends with the clock back at its idle level
   p_end_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !sclk);

   // R2: the clock stays low while no slot is being shifted
   p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SH_IDLE) |-> !sclk);

endmodule

// File: rtl/qsm_sequencer.sv
module qsm_sequencer
   import qsm_pkg::*;
#(
   parameter int unsigned IDX_W = 3,
   parameter int unsigned NCS   = 2,
   parameter int unsigned HALF  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_req,
   input  logic [IDX_W-1:0] start_ptr,
   input  logic [IDX_W-1:0] end_ptr,
   input  logic             cont_after,
   input  logic             cur_hold,
   input  logic             cur_dly,
   input  logic [NCS-1:0]   cur_dis,
   input  logic             shf_done,
   output logic [IDX_W-1:0] slot_idx,
   output logic             shf_go,
   output logic             shf_dly,
   output logic             busy,
   output logic             done,
   output logic [NCS-1:0]   cs_n
);

   localparam int unsigned GAP_W = $clog2(HALF + 1);

   seq_state_t       st_q;
   logic [GAP_W-1:0] gap_q;
   logic             cs_on_q;
   logic [NCS-1:0]   cs_sel_q;
   logic             last_slot;

   assign last_slot = (slot_idx == end_ptr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= SQ_IDLE;
         gap_q    <= '0;
         slot_idx <= '0;
         shf_go   <= 1'b0;
         shf_dly  <= 1'b0;
         busy     <= 1'b0;
         done     <= 1'b0;
         cs_on_q  <= 1'b0;
         cs_sel_q <= '0;
      end else begin
         shf_go <= 1'b0;
         done   <= 1'b0;
         case (st_q)
            SQ_IDLE: if (start_req) begin
               busy <= 1'b1;
               if (end_ptr < start_ptr) begin
                  st_q <= SQ_FINISH;
               end else begin
                  slot_idx <= start_ptr;
                  st_q     <= SQ_ISSUE;
               end
            end
            SQ_ISSUE: begin
               cs_on_q  <= 1'b1;
               cs_sel_q <= ~cur_dis;
               shf_go   <= 1'b1;
               shf_dly  <= cur_dly;
               st_q     <= SQ_WAIT;
            end
            SQ_WAIT: if (shf_done) begin
               if (last_slot) begin
                  if (!(cur_hold || cont_after)) cs_on_q <= 1'b0;
                  st_q <= SQ_FINISH;
               end else if (!cur_hold) begin
                  cs_on_q <= 1'b0;
                  gap_q   <= GAP_W'(HALF - 1);
                  st_q    <= SQ_GAP;
               end else begin
                  slot_idx <= slot_idx + 1'b1;
                  st_q     <= SQ_ISSUE;
               end
            end
            SQ_GAP: if (gap_q == '0) begin
               slot_idx <= slot_idx + 1'b1;
               st_q     <= SQ_ISSUE;
            end else gap_q <= gap_q - 1'b1;
            SQ_FINISH: begin
               busy <= 1'b0;
               done <= 1'b1;
               st_q <= SQ_IDLE;
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   assign cs_n = ~(cs_sel_q & {NCS{cs_on_q}});

   // R7: completion pulse lasts a single cycle
   p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7: completion coincides with the enable bit dropping
   p_done_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   // R10: an inverted window launches no slot
   p_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (start_req && !busy && (end_ptr < start_ptr)) |=> (!shf_go && $stable(cs_n)));

endmodule

// File: rtl/qspi_queue_master.sv
module qspi_queue_master
   import qsm_pkg::*;
#(
   parameter int unsigned SLOTS    = 8,
   parameter int unsigned NCS      = 2,
   parameter int unsigned CLK_DIV  = 4,
   parameter int unsigned LEAD_DLY = 3,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned ADDR_W   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso,
   output logic [NCS-1:0]    cs_n,
   output logic              done
);

   localparam int unsigned IDX_W = $clog2(SLOTS);
   localparam int unsigned HALF  = CLK_DIV / 2;

   generate
      if (SLOTS < 2 || SLOTS != (1 << IDX_W)) begin : g_bad_slots
         $error("SLOTS must be a power of two, at least 2");
      end
      if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("CLK_DIV must be even and at least 2");
      end
      if (NCS < 1 || NCS > 5) begin : g_bad_ncs
         $error("NCS must lie in 1..5 to fit the command word");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("DATA_W must hold a byte");
      end
      if ((4 * SLOTS + 4) > (1 << ADDR_W) || ADDR_W <= IDX_W) begin : g_bad_addr
         $error("ADDR_W too narrow for the register map");
      end
   endgenerate

   logic             busy, start_req, cont_after;
   logic [IDX_W-1:0] slot_idx, start_ptr, end_ptr;
   logic [7:0]       tx_byte, rx_byte;
   logic             cur_hold, cur_dly;
   logic [NCS-1:0]   cur_dis;
   logic             shf_go, shf_dly, shf_done;

   qsm_regfile #(
      .SLOTS(SLOTS), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCS(NCS)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .we(reg_we), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
      .busy(busy), .slot_idx(slot_idx), .tx_byte(tx_byte),
      .cur_hold(cur_hold), .cur_dly(cur_dly), .cur_dis(cur_dis),
      .rx_we(shf_done), .rx_data(rx_byte),
      .start_ptr(start_ptr), .end_ptr(end_ptr),
      .cont_after(cont_after), .start_req(start_req)
   );

   qsm_sequencer #(
      .IDX_W(IDX_W), .NCS(NCS), .HALF(HALF)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .start_req(start_req), .start_ptr(start_ptr), .end_ptr(end_ptr),
      .cont_after(cont_after), .cur_hold(cur_hold), .cur_dly(cur_dly),
      .cur_dis(cur_dis), .shf_done(shf_done),
      .slot_idx(slot_idx), .shf_go(shf_go), .shf_dly(shf_dly),
      .busy(busy), .done(done), .cs_n(cs_n)
   );

   qsm_shifter #(
      .HALF(HALF), .DLY(LEAD_DLY)
   ) u_shf (
      .clk(clk), .rst_n(rst_n),
      .go(shf_go), .dly(shf_dly), .tx_byte(tx_byte), .miso(miso),
      .sclk(sclk), .mosi(mosi), .rx_byte(rx_byte), .done(shf_done)
   );

   // R2: no clock activity outside a run
   p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sclk);

   // R1: a shift never starts while the engine is idle
   p_go_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
      shf_go |-> busy);

endmodule

// File: tb/qspi_queue_master_tb_top.sv
module qspi_queue_master_tb_top;

   localparam int SLOTS = 8;
   localparam int NCS   = 2;
   localparam int DLY   = 3;
   localparam int A_CMD = 2 * SLOTS;
   localparam int A_RX  = 3 * SLOTS;
   localparam int A_ST  = 4 * SLOTS;
   localparam int A_END = A_ST + 1;
   localparam int A_CTL = A_ST + 2;
   localparam int A_LCK = A_ST + 3;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           reg_we = 1'b0;
   logic [5:0]     reg_addr = '0;
   logic [7:0]     reg_wdata = '0;
   logic [7:0]     reg_rdata;
   logic           sclk, mosi, miso, done;
   logic [NCS-1:0] cs_n;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   qspi_queue_master dut_i (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk), .mosi(mosi),
      .miso(miso), .cs_n(cs_n), .done(done)
   );

   // ---------------- peripheral model ----------------
   int         rise_cnt = 0;
   int         cs0_rises = 0;
   logic [7:0] cap = '0;
   logic [7:0] mosi_log [512];

   function automatic logic [7:0] reply(input int n);
      return 8'(n * 73 + 53);
   endfunction

   function automatic logic reply_bit(input int n);
      logic [7:0] b;
      b = reply(n / 8);
      return b[7 - (n % 8)];
   endfunction

   assign miso = reply_bit(rise_cnt);

   always @(posedge sclk) begin
      cap = {cap[6:0], mosi};
      if (rise_cnt % 8 == 7) mosi_log[(rise_cnt / 8) % 512] = cap;
      rise_cnt++;
   end

   always @(posedge cs_n[0]) cs0_rises++;

   // lead measurement: select falling to first clock rise
   logic prev_cs0 = 1'b1;
   bit   measuring = 0;
   int   lead_cnt = 0;
   int   last_lead = 0;
   always @(negedge clk) begin
      if (cs_n[0] === 1'b0 && prev_cs0 === 1'b1) begin
         measuring = 1;
         lead_cnt  = 0;
      end else if (measuring) begin
         lead_cnt++;
         if (sclk) begin
            measuring = 0;
            last_lead = lead_cnt;
         end
      end
      prev_cs0 = cs_n[0];
   end

   // ---------------- helpers ----------------
   logic [7:0] tx_sh  [SLOTS];
   logic [7:0] cmd_sh [SLOTS];
   logic       exp_lvl [NCS];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      reg_we    = 1'b1;
      reg_addr  = 6'(a);
      reg_wdata = 8'(d);
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input int a, output int d);
      @(negedge clk);
      reg_addr = 6'(a);
      #1 d = int'(reg_rdata);
   endtask

   function automatic logic [7:0] mk_cmd(input bit hold, input bit dly, input logic [1:0] dis);
      return {hold, dly, 3'b000, dis, 1'b0};
   endfunction

   task automatic set_slot(input int s, input logic [7:0] tx, input logic [7:0] cmd);
      wr(2 * s, tx);
      wr(A_CMD + s, cmd);
      tx_sh[s]  = tx;
      cmd_sh[s] = cmd & 8'hFE;
   endtask

   task automatic run_q(input int sp, input int ep, input bit keep, input bit meddle);
      int base, nexp, cyc, d, exp_r;
      bit prev_spe;
      logic lvl [NCS];
      wr(A_ST, sp);
      wr(A_END, ep);
      // expected chip-select behaviour from the requirements
      for (int k = 0; k < NCS; k++) lvl[k] = exp_lvl[k];
      exp_r = 0;
      if (ep >= sp) begin
         for (int s = sp; s <= ep; s++) begin
            bit rel;
            for (int k = 0; k < NCS; k++) begin
               logic nv;
               nv = cmd_sh[s][k + 1];
               if (k == 0 && lvl[0] == 1'b0 && nv == 1'b1) exp_r++;
               lvl[k] = nv;
            end
            rel = (s == ep) ? !(cmd_sh[s][7] || keep) : !cmd_sh[s][7];
            if (rel) begin
               if (lvl[0] == 1'b0) exp_r++;
               for (int k = 0; k < NCS; k++) lvl[k] = 1'b1;
            end
         end
      end
      base      = rise_cnt;
      cs0_rises = 0;
      wr(A_CTL, keep ? 3 : 1);
      if (meddle) begin
         wr(A_END, 0);
         wr(0, ~tx_sh[0]);
         wr(A_CMD, cmd_sh[0] ^ 8'h80);
         wr(A_ST, 7);
      end
      reg_addr = 6'(A_CTL);
      cyc      = 0;
      prev_spe = 1'b1;
      while (cyc < 3000) begin
         @(negedge clk);
         #1;
         cyc++;
         if (done) break;
         prev_spe = reg_rdata[0];
      end
      chk(done == 1'b1, "R7 done seen", int'(done), 1);
      chk(prev_spe == 1'b1 && reg_rdata[0] == 1'b0, "R7 enable falls with done",
          int'(reg_rdata[0]), 0);
      if (ep < sp) chk(cyc <= 2, "R10 empty run length", cyc, 2);
      @(negedge clk);
      chk(done == 1'b0, "R7 done single cycle", int'(done), 0);
      nexp = (ep >= sp) ? (ep - sp + 1) * 8 : 0;
      chk(rise_cnt - base == nexp, (ep < sp) ? "R10 no clock edges" : "R2 clock edge count",
          rise_cnt - base, nexp);
      if (ep >= sp) begin
         for (int s = sp; s <= ep; s++) begin
            int j;
            j = base / 8 + (s - sp);
            chk(mosi_log[j % 512] == tx_sh[s], "R2 mosi byte", int'(mosi_log[j % 512]), int'(tx_sh[s]));
            rd(A_RX + s, d);
            chk(d == int'(reply(j)), "R3 receive byte", d, int'(reply(j)));
         end
      end
      chk(cs0_rises == exp_r, "R4 select release count", cs0_rises, exp_r);
      for (int k = 0; k < NCS; k++) begin
         chk(cs_n[k] == lvl[k], keep ? "R5 select level after run" : "R6 select level after run",
             int'(cs_n[k]), int'(lvl[k]));
         exp_lvl[k] = lvl[k];
      end
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      int d, lead_a, lead_b, v;
      v = int'($urandom(32'd1234));
      for (int k = 0; k < NCS; k++) exp_lvl[k] = 1'b1;
      for (int s = 0; s < SLOTS; s++) begin
         tx_sh[s]  = '0;
         cmd_sh[s] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      @(negedge clk);
      chk(sclk == 1'b0, "R1 sclk idle", int'(sclk), 0);
      chk(cs_n == '1, "R1 selects idle", int'(cs_n), 3);
      chk(done == 1'b0, "R1 done idle", int'(done), 0);
      rd(A_CTL, d);
      chk(d == 0, "R1 control word", d, 0);

      // R2 R3 R4: held slots then release, bit 0 of command reads 0
      set_slot(0, 8'hA5, mk_cmd(1, 0, 2'b00) | 8'h01);
      set_slot(1, 8'h3C, mk_cmd(1, 0, 2'b00));
      set_slot(2, 8'h81, mk_cmd(0, 0, 2'b00));
      set_slot(3, 8'h7E, mk_cmd(0, 0, 2'b10));
      rd(A_CMD, d);
      chk(d == 8'h80, "R4 command bit 0 reads 0", d, 8'h80);
      run_q(0, 3, 0, 0);

      // R11 lead delay
      set_slot(0, 8'h55, mk_cmd(0, 0, 2'b00));
      run_q(0, 0, 0, 0);
      lead_a = last_lead;
      set_slot(0, 8'h55, mk_cmd(0, 1, 2'b00));
      run_q(0, 0, 0, 0);
      lead_b = last_lead;
      chk(lead_b - lead_a == DLY, "R11 extra lead", lead_b - lead_a, DLY);

      // R5 keep after run, R10 empty run leaves select held
      set_slot(4, 8'hC3, mk_cmd(0, 0, 2'b10));
      set_slot(5, 8'h18, mk_cmd(0, 0, 2'b00));
      run_q(4, 5, 1, 0);
      run_q(5, 2, 0, 0);
      run_q(5, 5, 0, 0);

      // R8 writes during a run are ignored
      for (int s = 0; s < SLOTS; s++) set_slot(s, 8'(s * 29 + 7), mk_cmd(1, 0, 2'b00));
      cmd_sh[SLOTS - 1] = mk_cmd(0, 0, 2'b00);
      wr(A_CMD + SLOTS - 1, cmd_sh[SLOTS - 1]);
      run_q(0, SLOTS - 1, 0, 1);
      rd(A_END, d);
      chk(d == SLOTS - 1, "R8 end pointer kept", d, SLOTS - 1);
      rd(A_ST, d);
      chk(d == 0, "R8 start pointer kept", d, 0);
      rd(0, d);
      chk(d == int'(tx_sh[0]), "R8 transmit byte kept", d, int'(tx_sh[0]));
      rd(A_CMD, d);
      chk(d == int'(cmd_sh[0]), "R8 command kept", d, int'(cmd_sh[0]));

      // R9 lock
      wr(A_LCK, 1);
      wr(2, 8'hEE);
      wr(A_ST, 5);
      rd(2, d);
      chk(d == int'(tx_sh[1]), "R9 locked transmit byte", d, int'(tx_sh[1]));
      rd(A_ST, d);
      chk(d == 0, "R9 locked pointer", d, 0);
      wr(A_LCK, 0);
      wr(2, 8'hEE);
      tx_sh[1] = 8'hEE;
      rd(2, d);
      chk(d == 8'hEE, "R9 unlocked write", d, 8'hEE);

      // random queues: R2 R3 R4 R5 R6
      for (int r = 0; r < 8; r++) begin
         int sp, ep;
         for (int s = 0; s < SLOTS; s++)
            set_slot(s, 8'($urandom), mk_cmd(1'($urandom), 1'b0, 2'($urandom)));
         sp = int'($urandom % SLOTS);
         ep = sp + int'($urandom % (SLOTS - sp));
         run_q(sp, ep, 1'($urandom), 0);
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule